// File: doc/BRIEF.md
# Supply start-up and restart sequencer

This block supervises the bring-up of an off-line switching regulator. It reads digitized comparator flags describing the rectified line, the control-supply rail and the brown-out input. From them it decides when the high-voltage start-up current source charges the supply capacitor, and whether that current is the normal or the slowed setting. It also decides when the power switch may run, and which current-limit code the soft-start ramp presents to the current comparator.

After reset the sequencer charges the rail, provided the line is above its start level. When the rail reaches its on-threshold, charging stops and a soft-start ramps the limit code from zero to full scale in equal time steps. Switching then continues until the rail sags below its off-threshold or a fault is requested. After a stop, the charger stays off until the rail has fallen to the low restart level. After a fault, the next charge uses the reduced current, so restart attempts repeat slowly. A line below the start level parks the block in an inhibited state. The brown-out flag gates switching without changing the state.

Top module: `startup_seq`

## Requirements
- R1: `chg_en` is high only in the charging state and only while `line_ok` is high; a low `line_ok` forces it low in the same cycle.
- R2: In the charging state with `line_ok` high, a high `sup_hi` moves the block to soft-start at the next edge: `chg_en` falls and `sw_en` rises (if `brown_ok` is high) with `ilim_code` = 0.
- R3: `sw_en` is low in the charging, waiting and inhibited states; during soft-start or run, a high `sup_lo` makes `sw_en` low from the next edge.
- R4: After a stop with `line_ok` high, `chg_en` stays low until `sup_rearm` is seen high, and rises one edge after that.
- R5: `chg_slow` is 0 after reset; a fault request during soft-start or run sets it at the next edge; it clears when a soft-start completes into run, or in the inhibited state.
- R6: A low `line_ok` in the charging or waiting state moves the block to the inhibited state, where `chg_en` stays low whatever the rail flags are; a high `line_ok` then returns it to charging. Reset with `line_ok` low enters the inhibited state.
- R7: Every entry into soft-start restarts `ilim_code` at 0; the code rises by one after every STEP_CYCLES cycles with `brown_ok` high; after the step from full scale (all ones) the block enters run and `ilim_code` holds all ones; outside soft-start and run it reads 0.
- R8: While `brown_ok` is low, `sw_en` is low in the same cycle and the ramp is frozen; when it returns high, switching resumes in the same state without a new start.
- R9: A high `fault_req` during soft-start or run stops switching at the next edge and waits for the restart level, with priority over `sup_lo`; elsewhere it is ignored.
- R10: Reset is synchronous and active low; with `line_ok` high it enters charging with normal current (`chg_en` = 1, `chg_slow` = 0, `sw_en` = 0, `ilim_code` = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_ok | input | 1 | Rectified line above the start level |
| sup_hi | input | 1 | Control supply above its on-threshold |
| sup_lo | input | 1 | Control supply below its off-threshold |
| sup_rearm | input | 1 | Control supply below its restart threshold |
| brown_ok | input | 1 | Brown-out comparator reports an adequate line |
| fault_req | input | 1 | Fault request from the protection qualifier |
| chg_en | output | 1 | Start-up current source enable |
| chg_slow | output | 1 | 1 selects the reduced charge current |
| sw_en | output | 1 | Power switch enable |
| ilim_code | output | CODE_W | Soft-start current-limit code |

## Verification
The hardest case to reach is the slowed restart. A fault must land while the switch runs. The rail must then sit between the restart and off levels for a while. After that, a recharge and a complete soft-start must follow before the slow flag clears. Random rail levels rarely string these together. A directed sequence therefore walks the rail through that order, and random stimulus is added afterwards. In the random part, rail movement is biased upward while charging and downward while stopped, so hiccup cycles, brown-out dips inside the ramp, and line loss during the wait all recur.

// File: rtl/startup_seq_pkg.sv
// Shared types for the start-up sequencer.
// Assumes: five supervisory states, encoded in three bits.
package startup_seq_pkg;
    typedef enum logic [2:0] {
        ST_CHARGE         = 3'd0,
        ST_SOFTSTART      = 3'd1,
        ST_RUN            = 3'd2,
        ST_DISCHARGE_WAIT = 3'd3,
        ST_INHIBIT        = 3'd4
    } seq_state_t;
endpackage

// File: rtl/ss_step_timer.sv
// Step timer: produces one-cycle step pulses every DIV enabled cycles.
// Assumes: clr has priority over en; DIV >= 1.
module ss_step_timer #(
    parameter int DIV = 1062
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic step
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_direct
            // Every enabled cycle is a step.
            assign step = en;
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            // Count enabled cycles, wrapping at the step length.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt <= '0;
                end else if (en) begin
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
            end

            assign step = en && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/ss_ramp.sv
// Soft-start ramp code: climbs by one per step and saturates at full scale.
// Assumes: clr held for as long as soft-start is not active.
module ss_ramp #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] code,
    output logic         full
);
    assign full = (code == {W{1'b1}});

    // Advance the code on each step until full scale.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code <= '0;
        end else if (step && !full) begin
            code <= code + 1'b1;
        end
    end
endmodule

// File: rtl/seq_fsm.sv
// Supervisory state machine and slow-charge flag.
// Assumes: comparator flags are already synchronous to clk.
module seq_fsm
    import startup_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_ok,
    input  logic       sup_hi,
    input  logic       sup_lo,
    input  logic       sup_rearm,
    input  logic       fault_req,
    input  logic       step,
    input  logic       ramp_full,
    output seq_state_t state,
    output logic       slow
);
    seq_state_t nxt;
    logic       nxt_slow;

    // Next-state and slow-flag decision.
    always_comb begin
        nxt      = state;
        nxt_slow = slow;
        unique case (state)
            ST_CHARGE: begin
                if (!line_ok)    nxt = ST_INHIBIT;
                else if (sup_hi) nxt = ST_SOFTSTART;
            end
            ST_SOFTSTART: begin
                if (fault_req) begin
                    nxt      = ST_DISCHARGE_WAIT;
                    nxt_slow = 1'b1;
                end else if (sup_lo) begin
                    nxt = ST_DISCHARGE_WAIT;
                end else if (step && ramp_full) begin
                    nxt      = ST_RUN;
                    nxt_slow = 1'b0;
                end
            end
            ST_RUN: begin
                if (fault_req) begin
                    nxt      = ST_DISCHARGE_WAIT;
                    nxt_slow = 1'b1;
                end else if (sup_lo) begin
                    nxt = ST_DISCHARGE_WAIT;
                end
            end
            ST_DISCHARGE_WAIT: begin
                if (!line_ok)       nxt = ST_INHIBIT;
                else if (sup_rearm) nxt = ST_CHARGE;
            end
            ST_INHIBIT: begin
                nxt_slow = 1'b0;
                if (line_ok) nxt = ST_CHARGE;
            end
            default: nxt = ST_INHIBIT;
        endcase
    end

    // State register; reset chooses charging or inhibit from the line flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= line_ok ? ST_CHARGE : ST_INHIBIT;
            slow  <= 1'b0;
        end else begin
            state <= nxt;
            slow  <= nxt_slow;
        end
    end
endmodule

// File: rtl/startup_seq.sv
// Top of the start-up and auto-restart sequencer.
// Assumes: STEP_CYCLES reference cycles per ramp step; the whole soft-start
// spans 2**CODE_W steps of brown-out-qualified time.
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int STEP_CYCLES = 1062,
    parameter int CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_ok,
    input  logic              sup_hi,
    input  logic              sup_lo,
    input  logic              sup_rearm,
    input  logic              brown_ok,
    input  logic              fault_req,
    output logic              chg_en,
    output logic              chg_slow,
    output logic              sw_en,
    output logic [CODE_W-1:0] ilim_code
);
    seq_state_t        state;
    logic              slow;
    logic              step;
    logic              ramp_full;
    logic              ramp_clr;
    logic              ramp_run;
    logic [CODE_W-1:0] ramp_code;

    assign ramp_clr = (state != ST_SOFTSTART);
    assign ramp_run = (state == ST_SOFTSTART) && brown_ok;

    ss_step_timer #(.DIV(STEP_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ramp_clr),
        .en   (ramp_run),
        .step (step)
    );

    ss_ramp #(.W(CODE_W)) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ramp_clr),
        .step (step),
        .code (ramp_code),
        .full (ramp_full)
    );

    seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_ok  (line_ok),
        .sup_hi   (sup_hi),
        .sup_lo   (sup_lo),
        .sup_rearm(sup_rearm),
        .fault_req(fault_req),
        .step     (step),
        .ramp_full(ramp_full),
        .state    (state),
        .slow     (slow)
    );

    // Output decode from state and live gating flags.
    always_comb begin
        chg_en    = (state == ST_CHARGE) && line_ok;
        chg_slow  = slow;
        sw_en     = ((state == ST_SOFTSTART) || (state == ST_RUN)) && brown_ok;
        ilim_code = (state == ST_RUN)       ? {CODE_W{1'b1}} :
                    (state == ST_SOFTSTART) ? ramp_code : '0;
    end
endmodule

// File: rtl/startup_seq_checker.sv
// Port-level properties of the sequencer, bound into every instance.
// Assumes: rst_n is held low for at least one edge at start.
module startup_seq_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_ok,
    input logic              brown_ok,
    input logic              fault_req,
    input logic              sup_lo,
    input logic              chg_en,
    input logic              chg_slow,
    input logic              sw_en,
    input logic [CODE_W-1:0] ilim_code
);
    AST_CHG_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en |-> line_ok); // R1
    AST_NO_SW_WHILE_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en |-> !sw_en); // R3
    AST_STOP_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && sup_lo) |=> !sw_en); // R3
    AST_BROWN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !brown_ok |-> !sw_en); // R8
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && fault_req) |=> (!sw_en && !chg_en)); // R9
    AST_FAULT_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && fault_req) |=> chg_slow); // R5
    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_code != $past(ilim_code)) |->
            ((ilim_code == $past(ilim_code) + 1'b1) || (ilim_code == '0))); // R7
endmodule

bind startup_seq startup_seq_checker #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_ok  (line_ok),
    .brown_ok (brown_ok),
    .fault_req(fault_req),
    .sup_lo   (sup_lo),
    .chg_en   (chg_en),
    .chg_slow (chg_slow),
    .sw_en    (sw_en),
    .ilim_code(ilim_code)
);

// File: tb/startup_seq_test.sv
`timescale 1ns/1ps
module startup_seq_test;
    localparam int DIV = 3;
    localparam int CW  = 4;
    localparam int M_CH = 0, M_SS = 1, M_RN = 2, M_DW = 3, M_IN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_ok = 1'b0;
    logic sup_hi = 1'b0, sup_lo = 1'b1, sup_rearm = 1'b1;
    logic brown_ok = 1'b1, fault_req = 1'b0;
    logic chg_en, chg_slow, sw_en;
    logic [CW-1:0] ilim_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int lvl = 0;

    // reference model state
    int m_st = M_IN;
    bit m_slow = 1'b0;
    int m_code = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    startup_seq #(.STEP_CYCLES(DIV), .CODE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .line_ok(line_ok), .sup_hi(sup_hi),
        .sup_lo(sup_lo), .sup_rearm(sup_rearm), .brown_ok(brown_ok),
        .fault_req(fault_req), .chg_en(chg_en), .chg_slow(chg_slow),
        .sw_en(sw_en), .ilim_code(ilim_code)
    );

    // Behavioural model written from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= line_ok ? M_CH : M_IN;
            m_slow <= 1'b0;
        end else begin
            case (m_st)
                M_CH: if (!line_ok) m_st <= M_IN;
                      else if (sup_hi) begin m_st <= M_SS; m_code <= 0; m_cnt <= 0; end
                M_SS: if (fault_req) begin m_st <= M_DW; m_slow <= 1'b1; end
                      else if (sup_lo) m_st <= M_DW;
                      else if (brown_ok) begin
                          if (m_cnt == DIV - 1) begin
                              m_cnt <= 0;
                              if (m_code == 15) begin m_st <= M_RN; m_slow <= 1'b0; end
                              else m_code <= m_code + 1;
                          end else m_cnt <= m_cnt + 1;
                      end
                M_RN: if (fault_req) begin m_st <= M_DW; m_slow <= 1'b1; end
                      else if (sup_lo) m_st <= M_DW;
                M_DW: if (!line_ok) m_st <= M_IN;
                      else if (sup_rearm) m_st <= M_CH;
                default: begin m_slow <= 1'b0; if (line_ok) m_st <= M_CH; end
            endcase
        end
    end

    function automatic bit exp_chg();
        return (m_st == M_CH) && line_ok;
    endfunction
    function automatic bit exp_sw();
        return ((m_st == M_SS) || (m_st == M_RN)) && brown_ok;
    endfunction
    function automatic int exp_code();
        return (m_st == M_RN) ? 15 : (m_st == M_SS) ? m_code : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R1 chg_en", chg_en, exp_chg());
        chk("R5 chg_slow", chg_slow, m_slow);
        chk("R3 sw_en", sw_en, exp_sw());
        chk("R7 ilim_code", ilim_code, exp_code());
    endtask

    task automatic set_lvl(input int l);
        lvl = l;
        sup_rearm = (l == 0);
        sup_lo    = (l <= 1);
        sup_hi    = (l == 3);
    endtask

    // One clock edge, then compare at the following falling edge.
    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            cmp_model();
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=1 exp=0");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        // reset with line low -> inhibit
        set_lvl(0);
        line_ok = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 reset inhibit chg_en", chg_en, 0);
        line_ok = 1'b1;
        @(negedge clk);
        chk("R10 reset charge chg_en", chg_en, 1);
        chk("R10 reset chg_slow", chg_slow, 0);
        chk("R10 reset sw_en", sw_en, 0);
        chk("R10 reset ilim_code", ilim_code, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R4 charging holds chg_en", chg_en, 1);

        // reach on-threshold -> soft-start
        set_lvl(3);
        cyc(1);
        chk("R2 soft-start sw_en", sw_en, 1);
        chk("R2 soft-start chg_en", chg_en, 0);
        chk("R7 ramp starts at 0", ilim_code, 0);
        cyc(DIV - 1);
        chk("R7 code holds a step", ilim_code, 0);
        cyc(1);
        chk("R7 first step", ilim_code, 1);
        // brown-out in the ramp freezes it
        brown_ok = 1'b0;
        #1;
        chk("R8 brown-out gates sw_en", sw_en, 0);
        cyc(10);
        chk("R8 ramp frozen", ilim_code, 1);
        brown_ok = 1'b1;
        #1;
        chk("R8 resume sw_en", sw_en, 1);
        cyc(15 * DIV);
        chk("R7 run code full", ilim_code, 15);
        cyc(5);
        chk("R7 run holds full", ilim_code, 15);

        // fault while running -> slow restart
        fault_req = 1'b1;
        cyc(1);
        fault_req = 1'b0;
        chk("R9 fault stops sw_en", sw_en, 0);
        chk("R5 fault sets slow", chg_slow, 1);
        set_lvl(1);
        cyc(6);
        chk("R4 no recharge above restart", chg_en, 0);
        set_lvl(0);
        cyc(1);
        chk("R4 recharge after restart level", chg_en, 1);
        chk("R5 slow during recharge", chg_slow, 1);
        set_lvl(3);
        cyc(1);
        chk("R7 ramp restarts at 0", ilim_code, 0);
        cyc(16 * DIV);
        chk("R5 slow cleared in run", chg_slow, 0);
        chk("R7 full after restart", ilim_code, 15);

        // fault is ignored while charging
        set_lvl(1);
        cyc(1);
        chk("R3 stop on low supply", sw_en, 0);
        chk("R5 normal stop keeps normal current", chg_slow, 0);
        set_lvl(0);
        cyc(1);
        fault_req = 1'b1;
        cyc(2);
        fault_req = 1'b0;
        chk("R9 fault ignored in charge", chg_en, 1);
        chk("R9 fault ignored slow", chg_slow, 0);

        // line loss -> inhibit
        line_ok = 1'b0;
        #1;
        chk("R1 line loss drops chg_en", chg_en, 0);
        cyc(3);
        chk("R6 inhibit holds chg_en low", chg_en, 0);
        line_ok = 1'b1;
        cyc(1);
        chk("R6 line return charges", chg_en, 1);

        // constrained random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 8);
            if (chg_en && r < 3 && lvl < 3) set_lvl(lvl + 1);
            else if (!sw_en && !chg_en && r < 2 && lvl > 0) set_lvl(lvl - 1);
            else if (sw_en && r == 6 && ($urandom % 16 == 0) && lvl > 0) set_lvl(lvl - 1);
            else if (r == 7 && ($urandom % 4 == 0)) set_lvl((lvl < 3) ? lvl + 1 : lvl - 1);
            if ($urandom % 300 == 0) line_ok = ~line_ok;
            if (brown_ok && ($urandom % 64 == 0)) brown_ok = 1'b0;
            else if (!brown_ok && ($urandom % 8 == 0)) brown_ok = 1'b1;
            fault_req = ($urandom % 150 == 0);
            #1;
            cmp_model();
            cyc(1);
        end
        finish_run();
    end
endmodule